// File: doc/BRIEF.md
# Chroma-from-Luma Prediction Datapath

This block turns a stream of signed AC luma samples, each scaled by eight (three fractional bits), into chroma prediction pixels. Every pixel is the block's DC level plus the AC sample scaled by a signed weight. The weight also carries three fractional bits. The result is rounded and then held inside the legal pixel range for the chosen bit depth. The multiply runs on magnitudes only. The sign is put back afterwards with a mask-add-XOR step, and the DC level is then added in 16-bit two's-complement arithmetic.

The block accepts one sample per clock on a valid/ready input and delivers pixels in the same order on a valid/ready output, three register stages later. A sample that arrives with the start-of-block flag set loads the weight, the DC level and the bit depth. Those settings apply to that sample and to every later sample until the next start-of-block flag.

Top module: `cfl_pred_path`

## Requirements
- R1: The weight magnitude in Q12 is the low 16 bits of |alpha| shifted left by 9, taken as unsigned. The scaled magnitude is m = min(32767, (2·|ac|·q12 + 32768) >> 16), where |ac| of -32768 is 32768.
- R2: The signed scaled value is -m when exactly one of alpha and ac is negative, and +m otherwise.
- R3: The DC level, zero-extended, is added to the signed scaled value modulo 2^16, and the sum is read as signed 16-bit. An overflow past +32767 wraps to a negative value.
- R4: The output pixel is 0 for a negative sum, 2^b−1 for a sum above that, and the sum otherwise. Here b is bd_i, and a bd_i above PIX_W is treated as PIX_W.
- R5: With bd_i = 8 the output is limited to the range 0..255.
- R6: When a sample is accepted with sop_i = 1, alpha_i, dc_i and bd_i are captured and apply to that sample and to later ones. On an accepted sample with sop_i = 0, these inputs are ignored and the captured values are used.
- R7: With ready_i held high, a sample accepted at clock edge k appears on valid_o/pix_o after edge k+2. One sample per cycle is sustained.
- R8: While valid_o = 1 and ready_i = 0, pix_o and valid_o hold and in_ready_o is low. No sample is lost or duplicated, and order is preserved.
- R9: During and after reset, valid_o is 0 and in_ready_o is 1 until data enters the pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Input sample valid |
| in_ready_o | output | 1 | Input sample accepted when high with in_valid_i |
| sop_i | input | 1 | Sample starts a new block; capture configuration |
| ac_i | input | 16 | Signed AC luma sample, three fractional bits |
| alpha_i | input | ALPHA_W | Signed weight, three fractional bits |
| dc_i | input | PIX_W | Unsigned DC level |
| bd_i | input | BD_W | Bit depth of the output pixel |
| valid_o | output | 1 | Output pixel valid |
| ready_i | input | 1 | Downstream accepts pixel |
| pix_o | output | PIX_W | Unsigned predicted pixel |

## Verification
Capturing a new configuration can happen in the same cycle as an output stall. At that moment samples of the previous block are still inside the pipeline and must keep their own weight and DC. This overlap is provoked by issuing start-of-block samples back to back, each with a different weight, DC level and bit depth, while ready_i is randomly deasserted. Each sample's expected pixel is fixed by the reference model at the moment the sample is accepted. Every delivered pixel is compared against the queue in order, so a sample that picked up the newer settings shows up as a mismatch.

// File: rtl/cfl_pred_pkg.sv
package cfl_pred_pkg;
  localparam int unsigned AC_W  = 16;
  localparam int unsigned Q12_W = 16;
  localparam int unsigned Q12_SH = 9;
  localparam int unsigned PROD_W = AC_W + Q12_W;
  localparam logic [AC_W-1:0] SMAX = {1'b0, {(AC_W-1){1'b1}}};
endpackage

// File: rtl/cfl_mag_mul.sv
module cfl_mag_mul
  import cfl_pred_pkg::*;
#(
  parameter int unsigned ALPHA_W = 7,
  parameter int unsigned PIX_W   = 12,
  parameter int unsigned BD_W    = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      en_i,
  input  logic                      valid_i,
  input  logic signed [AC_W-1:0]    ac_i,
  input  logic signed [ALPHA_W-1:0] alpha_i,
  input  logic [PIX_W-1:0]          dc_i,
  input  logic [BD_W-1:0]           bd_i,
  output logic                      valid_o,
  output logic [AC_W-1:0]           mag_o,
  output logic                      neg_o,
  output logic [PIX_W-1:0]          dc_o,
  output logic [PIX_W-1:0]          max_o
);
  localparam int unsigned AW1 = ALPHA_W + 1;

  logic [AC_W:0]     ac_ext, ac_abs;
  logic [AW1-1:0]    al_ext, al_abs;
  logic [31:0]       al_sh;
  logic [Q12_W-1:0]  q12;
  logic [PROD_W-1:0] prod;
  logic [PROD_W:0]   rnd;
  logic [AC_W:0]     hi;
  logic [AC_W-1:0]   mag_d;
  logic [BD_W-1:0]   bd_eff;
  logic [PIX_W:0]    one_sh;
  logic [PIX_W:0]    max_full;

  always_comb begin
    ac_ext = {ac_i[AC_W-1], ac_i};
    ac_abs = ac_i[AC_W-1] ? (~ac_ext + 1'b1) : ac_ext;
    al_ext = {alpha_i[ALPHA_W-1], alpha_i};
    al_abs = alpha_i[ALPHA_W-1] ? (~al_ext + 1'b1) : al_ext;
    al_sh  = 32'(al_abs) << Q12_SH;
    q12    = al_sh[Q12_W-1:0];
    prod   = PROD_W'(ac_abs[AC_W-1:0]) * PROD_W'(q12);
    rnd    = {prod, 1'b0} + (PROD_W+1)'(1 << (AC_W - 1));
    hi     = rnd[PROD_W:AC_W];
    mag_d  = (hi > (AC_W+1)'(SMAX)) ? SMAX : hi[AC_W-1:0];
    bd_eff = (bd_i > BD_W'(PIX_W)) ? BD_W'(PIX_W) : bd_i;
    one_sh = (PIX_W+1)'(1) << bd_eff;
    max_full = one_sh - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      mag_o   <= '0;
      neg_o   <= 1'b0;
      dc_o    <= '0;
      max_o   <= '0;
    end else if (en_i) begin
      valid_o <= valid_i;
      mag_o   <= mag_d;
      neg_o   <= alpha_i[ALPHA_W-1] ^ ac_i[AC_W-1];
      dc_o    <= dc_i;
      max_o   <= max_full[PIX_W-1:0];
    end
  end

  // R1: zero AC yields zero magnitude whatever the weight
  a_r1_zero_ac: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && valid_i && ac_i == '0) |=> (mag_o == '0));
endmodule

// File: rtl/cfl_sign_dc.sv
module cfl_sign_dc
  import cfl_pred_pkg::*;
#(
  parameter int unsigned PIX_W = 12
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   en_i,
  input  logic                   valid_i,
  input  logic [AC_W-1:0]        mag_i,
  input  logic                   neg_i,
  input  logic [PIX_W-1:0]       dc_i,
  input  logic [PIX_W-1:0]       max_i,
  output logic                   valid_o,
  output logic signed [AC_W-1:0] sum_o,
  output logic [PIX_W-1:0]       max_o
);
  logic [AC_W-1:0] mask, signed_val, sum_d;

  always_comb begin
    mask       = {AC_W{neg_i}};
    signed_val = (mag_i + mask) ^ mask;
    sum_d      = signed_val + AC_W'(dc_i);  // 16-bit wrap intended
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      sum_o   <= '0;
      max_o   <= '0;
    end else if (en_i) begin
      valid_o <= valid_i;
      sum_o   <= sum_d;
      max_o   <= max_i;
    end
  end

  // R2: negative sign with nonzero magnitude and no DC gives a negative result
  a_r2_sign_restore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && valid_i && neg_i && mag_i != '0 && dc_i == '0) |=> (sum_o < 0));
endmodule

// File: rtl/cfl_clamp.sv
module cfl_clamp
  import cfl_pred_pkg::*;
#(
  parameter int unsigned PIX_W = 12
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   en_i,
  input  logic                   valid_i,
  input  logic signed [AC_W-1:0] sum_i,
  input  logic [PIX_W-1:0]       max_i,
  output logic                   valid_o,
  output logic [PIX_W-1:0]       pix_o
);
  logic [PIX_W-1:0] pix_d;
  logic [PIX_W-1:0] max_q;

  always_comb begin
    if (sum_i < 0)                            pix_d = '0;
    else if ($unsigned(sum_i) > AC_W'(max_i)) pix_d = max_i;
    else                                      pix_d = sum_i[PIX_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      pix_o   <= '0;
      max_q   <= '0;
    end else if (en_i) begin
      valid_o <= valid_i;
      pix_o   <= pix_d;
      max_q   <= max_i;
    end
  end

  // R4: delivered pixel never exceeds the ceiling of its sample
  a_r4_ceiling: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (pix_o <= max_q));
  // R4: negative sum leaves as zero
  a_r4_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && valid_i && sum_i < 0) |=> (pix_o == '0));
endmodule

// File: rtl/cfl_pred_path.sv
module cfl_pred_path
  import cfl_pred_pkg::*;
#(
  parameter int unsigned ALPHA_W = 7,
  parameter int unsigned PIX_W   = 12,
  parameter int unsigned BD_W    = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      in_valid_i,
  output logic                      in_ready_o,
  input  logic                      sop_i,
  input  logic signed [AC_W-1:0]    ac_i,
  input  logic signed [ALPHA_W-1:0] alpha_i,
  input  logic [PIX_W-1:0]          dc_i,
  input  logic [BD_W-1:0]           bd_i,
  output logic                      valid_o,
  input  logic                      ready_i,
  output logic [PIX_W-1:0]          pix_o
);
  logic                      en, take;
  logic signed [ALPHA_W-1:0] cfg_alpha_q, alpha_use;
  logic [PIX_W-1:0]          cfg_dc_q, dc_use;
  logic [BD_W-1:0]           cfg_bd_q, bd_use;

  logic                    s1_v, s1_neg, s2_v;
  logic [AC_W-1:0]         s1_mag;
  logic [PIX_W-1:0]        s1_dc, s1_max, s2_max;
  logic signed [AC_W-1:0]  s2_sum;

  // single advance strobe: any stage moves only when the last can drain
  assign en         = !valid_o || ready_i;
  assign in_ready_o = en;
  assign take       = in_valid_i && in_ready_o;

  assign alpha_use = sop_i ? alpha_i : cfg_alpha_q;
  assign dc_use    = sop_i ? dc_i    : cfg_dc_q;
  assign bd_use    = sop_i ? bd_i    : cfg_bd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_alpha_q <= '0;
      cfg_dc_q    <= '0;
      cfg_bd_q    <= BD_W'(8);
    end else if (take && sop_i) begin
      cfg_alpha_q <= alpha_i;
      cfg_dc_q    <= dc_i;
      cfg_bd_q    <= bd_i;
    end
  end

  cfl_mag_mul #(.ALPHA_W(ALPHA_W), .PIX_W(PIX_W), .BD_W(BD_W)) i_mul (
    .clk_i, .rst_ni, .en_i(en), .valid_i(in_valid_i),
    .ac_i, .alpha_i(alpha_use), .dc_i(dc_use), .bd_i(bd_use),
    .valid_o(s1_v), .mag_o(s1_mag), .neg_o(s1_neg), .dc_o(s1_dc), .max_o(s1_max)
  );

  cfl_sign_dc #(.PIX_W(PIX_W)) i_sign (
    .clk_i, .rst_ni, .en_i(en), .valid_i(s1_v),
    .mag_i(s1_mag), .neg_i(s1_neg), .dc_i(s1_dc), .max_i(s1_max),
    .valid_o(s2_v), .sum_o(s2_sum), .max_o(s2_max)
  );

  cfl_clamp #(.PIX_W(PIX_W)) i_clamp (
    .clk_i, .rst_ni, .en_i(en), .valid_i(s2_v),
    .sum_i(s2_sum), .max_i(s2_max), .valid_o(valid_o), .pix_o(pix_o)
  );

  // R8: stalled output holds
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(pix_o)));
  // R8: stalled output blocks input
  a_r8_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |-> !in_ready_o);
  // R9: empty output never refuses input
  a_r9_ready_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> in_ready_o);
  // R6: non-start samples leave the captured settings alone
  a_r6_cfg_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && !sop_i) |=> ($stable(cfg_alpha_q) && $stable(cfg_dc_q) && $stable(cfg_bd_q)));
endmodule

// File: tb/test_cfl_pred_path.sv
`timescale 1ns/100ps
module test_cfl_pred_path;
  localparam int ALPHA_W = 7;
  localparam int PIX_W   = 12;
  localparam int BD_W    = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, sop = 1'b0, ready = 1'b1;
  logic signed [15:0] ac = '0;
  logic signed [ALPHA_W-1:0] alpha = '0;
  logic [PIX_W-1:0] dc = '0;
  logic [BD_W-1:0] bd = BD_W'(8);
  logic in_ready, valid_o;
  logic [PIX_W-1:0] pix;

  int checks = 0, errors = 0, sent = 0, recv = 0;
  int exp_q[$];
  string tag_q[$];
  string cur_tag = "R1";
  bit rand_ready = 1'b0;
  int h_alpha = 0, h_dc = 0, h_bd = 8;
  bit stall_seen = 1'b0;
  logic [PIX_W-1:0] stall_pix = '0;

  always #2.5 clk = ~clk;

  cfl_pred_path #(.ALPHA_W(ALPHA_W), .PIX_W(PIX_W), .BD_W(BD_W)) i_cfl_pred_path (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .sop_i(sop), .ac_i(ac), .alpha_i(alpha), .dc_i(dc), .bd_i(bd),
    .valid_o(valid_o), .ready_i(ready), .pix_o(pix)
  );

  function automatic int ref_pix(int a, int x, int d, int b);
    longint q12, m, r, s, mx;
    int e;
    q12 = ((a < 0 ? -a : a) << 9) & 16'hFFFF;
    m = (2 * longint'(x < 0 ? -x : x) * q12 + 32768) >>> 16;
    if (m > 32767) m = 32767;
    r = ((a < 0) != (x < 0)) ? -m : m;
    s = (r + d) & 16'hFFFF;
    if (s > 32767) s = s - 65536;
    e = (b > PIX_W) ? PIX_W : b;
    mx = (longint'(1) << e) - 1;
    if (s < 0) return 0;
    if (s > mx) return int'(mx);
    return int'(s);
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference model and output comparison, away from the active edge
  always @(negedge clk) if (rst_n) begin
    if (in_valid && in_ready) begin
      if (sop) begin h_alpha = int'(alpha); h_dc = int'(dc); h_bd = int'(bd); end
      exp_q.push_back(ref_pix(h_alpha, int'(ac), h_dc, h_bd));
      tag_q.push_back(cur_tag);
      sent++;
    end
    if (stall_seen) begin
      check("R8 hold valid", int'(valid_o), 1);
      check("R8 hold pix", int'(pix), int'(stall_pix));
    end
    stall_seen = valid_o && !ready;
    stall_pix = pix;
    if (valid_o && ready) begin
      recv++;
      if (exp_q.size() == 0) check("R8 extra output", 1, 0);
      else check(tag_q.pop_front(), int'(pix), exp_q.pop_front());
    end
  end

  initial forever begin
    @(posedge clk); #1;
    ready = rand_ready ? ($urandom % 3 != 0) : 1'b1;
  end

  task automatic send(int a, int x, int d, int b, bit s);
    alpha = ALPHA_W'(a); ac = 16'(x); dc = PIX_W'(d); bd = BD_W'(b); sop = s;
    in_valid = 1'b1;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 1'b0; sop = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 2000 && (exp_q.size() != 0 || valid_o); i++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9 valid in reset", int'(valid_o), 0);
    check("R9 ready in reset", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 valid after reset", int'(valid_o), 0);
    check("R9 ready after reset", int'(in_ready), 1);
    @(posedge clk); #1;

    // R7 latency with no stall
    cur_tag = "R7";
    send(8, 800, 100, 10, 1'b1);
    @(negedge clk); check("R7 not yet k+1", int'(valid_o), 0);
    @(negedge clk); check("R7 not yet k+2", int'(valid_o), 0);
    @(negedge clk); check("R7 out after k+2", int'(valid_o), 1);
    drain();

    cur_tag = "R1 saturate";  send(-64, -32768, 0, 12, 1'b1);
    cur_tag = "R1 max pos";   send(63, 32767, 0, 12, 1'b1);
    cur_tag = "R1 zero alpha"; send(0, 12345, 77, 12, 1'b1);
    cur_tag = "R2 neg alpha"; send(-5, 3000, 2000, 12, 1'b1);
    cur_tag = "R2 neg ac";    send(5, -3000, 2000, 12, 1'b1);
    cur_tag = "R2 both neg";  send(-5, -3000, 2000, 12, 1'b1);
    cur_tag = "R3 dc wrap";   send(63, 32767, 4095, 12, 1'b1);
    cur_tag = "R4 below zero"; send(-20, 20000, 10, 10, 1'b1);
    cur_tag = "R4 bd over width"; send(10, 30000, 0, 15, 1'b1);
    cur_tag = "R5 8-bit top"; send(16, 4000, 200, 8, 1'b1);
    cur_tag = "R5 8-bit mid"; send(-3, 400, 128, 8, 1'b1);
    // R6: changed settings without a start flag are ignored
    cur_tag = "R6 capture";   send(7, 1000, 300, 9, 1'b1);
    cur_tag = "R6 ignored";   send(-40, 1000, 9, 12, 1'b0);
    cur_tag = "R6 ignored2";  send(60, -500, 4000, 8, 1'b0);
    drain();

    // R8: back-to-back blocks under random backpressure
    rand_ready = 1'b1;
    for (int i = 0; i < 400; i++) begin
      int b;
      b = 8 + ($urandom % 5);
      cur_tag = "R8 stream";
      send(int'($urandom % 128) - 64, int'($urandom % 65536) - 32768,
           int'($urandom % (1 << b)), b, ($urandom % 6 == 0) || (i % 9 == 0));
    end
    rand_ready = 1'b0;
    drain();
    check("R8 all delivered", recv, sent);
    check("R8 queue empty", exp_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R8 watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule